// File: doc/BRIEF.md
# Divided Countdown Interrupt Timer

This block is a 32-bit down-counter that runs from a prescaled copy of the core clock. Software loads a start value. The count then falls by one on every prescaled tick. When it reaches zero, the block raises a one-cycle interrupt request, unless that request is masked. A per-timer control entry selects between two modes. In one-shot mode the count stops at zero. In periodic mode the count reloads itself on the tick after zero, so each period passes through the start value plus one states.

A small register port connects the timer to the rest of the chip. It has a write strobe with a 2-bit register select and a 32-bit data word, and a combinational read path with its own select. The four registers are:

- Start value (select 0).
- Live count, read-only (select 1).
- Prescale configuration (select 2).
- Control entry (select 3).

The prescale configuration uses three scattered bits as a divide code. Seven of the codes select a division by a power of two, from 2 up to 128. The remaining code selects no division.

Top module: `div_countdown_timer`

## Requirements
- R1: After reset, all four registers read as follows:
  - Start value reads 0.
  - Live count reads 0.
  - Prescale configuration reads 0.
  - Control entry reads 0x0001_0000, which means masked and one-shot.
  - The interrupt output is low.
- R2: A write to the prescale configuration keeps only data bits 3, 1 and 0; the other bits read back as zero.
- R3: The prescale configuration forms a 3-bit divide code.
  - Code bit 2 is configuration bit 3, and code bits 1:0 are configuration bits 1:0.
  - The count steps once every 2^((code+1) mod 8) clock cycles.
  - Code 7 therefore steps on every cycle, and code 0 steps every 2 cycles.
- R4: In one-shot mode, let N be the number of cycles since the clock edge that wrote the start value S, and let D be the divisor.
  - The live count reads S − floor(N/D) until that value reaches 0, and then stays at 0.
  - The interrupt fires exactly once, when N = S·D.
- R5: Writing the start value restarts the timer.
  - The count takes the new value and the prescaler phase returns to zero.
  - An expiry that was due from the earlier load does not happen.
- R6: In periodic mode (control bit 17 set), the count reloads the start value on the tick after it reaches 0. Interrupts therefore fire every (S+1)·D cycles, with the first one at S·D.
- R7: Setting the mask (control bit 16) suppresses the interrupt, but the count keeps running.
- R8: The interrupt output is registered. It is high for exactly the one cycle after the clock edge on which the count becomes 0.
- R9: A start value of 0 stops the timer. The live count stays 0 and no interrupt fires.
- R10: Writes to the live-count select are ignored and do not disturb the running count.
- R11: The control entry keeps only bit 16 (mask) and bit 17 (periodic); every other bit reads back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write select: 0 start, 1 live count, 2 prescale, 3 control |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read select, same encoding as wr_sel |
| rd_data | output | 32 | Combinational read data |
| irq | output | 1 | One-cycle interrupt request |

## Verification
A scoreboard checks the exact cycle of every interrupt, so an off-by-one in the prescaler or counter shows up as a mismatch. In particular, a prescaler that keeps its old phase across a reload moves the expiry cycle. The divide codes tested include the scattered-bit case (configuration bit 3 alone) and the wrapping code that means no division. A wrong bit mapping would give a different divisor and a different expiry cycle.

Periodic mode is tested with start values of 1 and 3. A design that skips the zero state, or that reloads one tick late, fires at the wrong spacing. Masking is tested to confirm the count keeps running while the interrupt stays quiet. Other checks cover:
- A reload in mid-count that must cancel the pending expiry.
- Stopping with a start value of zero.
- Writes to the read-only count, which must not alter the count.

// File: rtl/dct_pkg.sv
package dct_pkg;

   typedef enum logic [1:0] {
      SEL_START = 2'd0,
      SEL_LIVE  = 2'd1,
      SEL_PRE   = 2'd2,
      SEL_CTRL  = 2'd3
   } dct_sel_e;

   localparam int CTRL_MASK_BIT = 16;
   localparam int CTRL_PER_BIT  = 17;

   typedef struct packed {
      logic periodic;
      logic mask;
   } dct_ctrl_t;

   // divide code -> shift amount, wrapping modulo 8 (code 7 -> no division)
   function automatic logic [2:0] code_to_shift(input logic [2:0] code);
      return code + 3'd1;
   endfunction

endpackage

// File: rtl/dct_prescale.sv
module dct_prescale #(
   parameter int SHIFT_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               restart,
   input  logic [SHIFT_W-1:0] shift,
   output logic               tick
);
   localparam int PRE_W = (1 << SHIFT_W) - 1;

   logic [PRE_W-1:0] cnt;
   logic [PRE_W:0]   limit;

   generate
      if (SHIFT_W < 1 || SHIFT_W > 4) begin : g_bad_shift_w
         $error("dct_prescale: SHIFT_W out of range");
      end
   endgenerate

   always_comb begin
      limit = ({{PRE_W{1'b0}}, 1'b1} << shift) - 1'b1;
      tick  = !restart && ({1'b0, cnt} >= limit);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt <= '0;
      else if (restart || tick)  cnt <= '0;
      else                       cnt <= cnt + 1'b1;
   end

   // R5: a restart or a tick returns the prescaler phase to zero
   assert_phase_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick || restart) |=> (cnt == '0));

endmodule

// File: rtl/dct_counter.sv
module dct_counter #(
   parameter int COUNT_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [COUNT_W-1:0] load_val,
   input  logic [COUNT_W-1:0] reload,
   input  logic               tick,
   input  logic               periodic,
   input  logic               mask,
   output logic [COUNT_W-1:0] cur,
   output logic               irq
);
   localparam logic [COUNT_W-1:0] ONE = COUNT_W'(1);

   logic running;
   logic at_end;

   always_comb begin
      running = tick && (reload != '0);
      at_end  = (cur == ONE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur <= '0;
         irq <= 1'b0;
      end else if (load) begin
         cur <= load_val;
         irq <= 1'b0;
      end else begin
         irq <= running && at_end && !mask;
         if (running) begin
            if (cur != '0)     cur <= cur - 1'b1;
            else if (periodic) cur <= reload;
         end
      end
   end

   // R8: the request never stays high on two cycles in a row
   assert_irq_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);
   // R7: a request only follows a cycle with the mask clear
   assert_irq_unmasked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(!mask));
   // R9: no request while the start value was zero
   assert_stop_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(reload != '0));
   // R4: a finished one-shot count holds at zero
   assert_oneshot_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !periodic && cur == '0) |=> (cur == '0));
   // R6: the live count never exceeds the start value
   assert_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !load |-> (cur <= reload));

endmodule

// File: rtl/div_countdown_timer.sv
module div_countdown_timer
   import dct_pkg::*;
#(
   parameter int COUNT_W = 32,
   parameter int SHIFT_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [1:0]         wr_sel,
   input  logic [COUNT_W-1:0] wr_data,
   input  logic [1:0]         rd_sel,
   output logic [COUNT_W-1:0] rd_data,
   output logic               irq
);
   localparam int CODE_W = 3;

   generate
      if (COUNT_W < CTRL_PER_BIT + 1) begin : g_bad_count_w
         $error("div_countdown_timer: COUNT_W too narrow for control bits");
      end
      if (SHIFT_W != CODE_W) begin : g_bad_shift_w
         $error("div_countdown_timer: SHIFT_W must match the 3-bit divide code");
      end
   endgenerate

   logic [COUNT_W-1:0] start_q;
   logic [CODE_W-1:0]  code_q;
   dct_ctrl_t          ctrl_q;
   logic               load;
   logic               tick;
   logic [COUNT_W-1:0] live;
   logic [SHIFT_W-1:0] shift;

   always_comb begin
      load  = wr_en && (wr_sel == SEL_START);
      shift = SHIFT_W'(code_to_shift(code_q));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= '0;
         code_q  <= '0;
         ctrl_q  <= '{periodic: 1'b0, mask: 1'b1};
      end else if (wr_en) begin
         case (wr_sel)
            SEL_START: start_q <= wr_data;
            SEL_PRE:   code_q  <= {wr_data[3], wr_data[1:0]};
            SEL_CTRL:  ctrl_q  <= '{periodic: wr_data[CTRL_PER_BIT],
                                    mask:     wr_data[CTRL_MASK_BIT]};
            default:   ;
         endcase
      end
   end

   always_comb begin
      rd_data = '0;
      case (rd_sel)
         SEL_START: rd_data = start_q;
         SEL_LIVE:  rd_data = live;
         SEL_PRE:   rd_data[3:0] = {code_q[2], 1'b0, code_q[1:0]};
         default: begin
            rd_data[CTRL_MASK_BIT] = ctrl_q.mask;
            rd_data[CTRL_PER_BIT]  = ctrl_q.periodic;
         end
      endcase
   end

   dct_prescale #(.SHIFT_W(SHIFT_W)) i_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (load),
      .shift   (shift),
      .tick    (tick)
   );

   dct_counter #(.COUNT_W(COUNT_W)) i_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (wr_data),
      .reload   (start_q),
      .tick     (tick),
      .periodic (ctrl_q.periodic),
      .mask     (ctrl_q.mask),
      .cur      (live),
      .irq      (irq)
   );

   // R5: a start-value write is visible in the live count on the next cycle
   assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (live == start_q));
   // R10: writes aimed at the live count leave the stored start value alone
   assert_live_ro_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_LIVE) |=> $stable(start_q));

endmodule

// File: tb/test_div_countdown_timer.sv
module test_div_countdown_timer;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en;
   logic [1:0]  wr_sel;
   logic [31:0] wr_data;
   logic [1:0]  rd_sel;
   logic [31:0] rd_data;
   logic        irq;

   always #4 clk = ~clk;   // 125 MHz

   div_countdown_timer i_div_countdown_timer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq)
   );

   int cyc = 0;
   int total = 0;
   int bad = 0;
   int expq[$];
   int exp_c;
   bit finished = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic wr(input logic [1:0] s, input logic [31:0] d, output int at);
      wr_en = 1'b1; wr_sel = s; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      at = cyc;
   endtask

   task automatic rd_chk(input string req, input logic [1:0] s, input logic [31:0] exp);
      rd_sel = s;
      #1;
      chk(req, rd_data, exp);
   endtask

   task automatic wait_to(input int n);
      while (cyc < n) @(negedge clk);
   endtask

   // monitor: every request must match the next expected cycle (R4 R6 R7 R8 R9)
   always @(negedge clk) begin
      if (rst_n === 1'b1 && !finished && irq === 1'b1) begin
         total++;
         if (expq.size() == 0) begin
            bad++;
            $display("FAIL R7/R9 unexpected irq actual=%0d expected=none", cyc);
         end else begin
            exp_c = expq.pop_front();
            if (exp_c != cyc) begin
               bad++;
               $display("FAIL R8 irq cycle actual=%0d expected=%0d", cyc, exp_c);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int L, L2, dummy;
      rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0; rd_sel = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 irq", {31'd0, irq}, 32'd0);
      rd_chk("R1 start", 2'd0, 32'd0);
      rd_chk("R1 live", 2'd1, 32'd0);
      rd_chk("R1 prescale", 2'd2, 32'd0);
      rd_chk("R1 ctrl", 2'd3, 32'h0001_0000);

      // R2 prescale keeps bits 3,1,0
      wr(2'd2, 32'hFF, dummy);
      rd_chk("R2 keep 0xB", 2'd2, 32'hB);
      wr(2'd2, 32'h4, dummy);
      rd_chk("R2 drop bit2", 2'd2, 32'h0);

      // R11 control keeps bits 16,17
      wr(2'd3, 32'hFFFF_FFFF, dummy);
      rd_chk("R11 ctrl bits", 2'd3, 32'h0003_0000);

      // R4 one-shot, divide by 2
      wr(2'd2, 32'h0, dummy);
      wr(2'd3, 32'h0, dummy);
      wr(2'd0, 32'd5, L);
      expq.push_back(L + 10);
      wait_to(L + 3);  rd_chk("R4 live mid", 2'd1, 32'd4);
      wait_to(L + 9);  rd_chk("R4 live last", 2'd1, 32'd1);
      wait_to(L + 10); rd_chk("R4 live zero", 2'd1, 32'd0);
      wait_to(L + 30); rd_chk("R4 one-shot holds", 2'd1, 32'd0);

      // R3 code 7 -> no division
      wr(2'd2, 32'hB, dummy);
      wr(2'd0, 32'd3, L);
      expq.push_back(L + 3);
      wait_to(L + 1);  rd_chk("R3 div1 step", 2'd1, 32'd2);
      wait_to(L + 10);

      // R3 config bit 3 alone -> code 4 -> divide by 32
      wr(2'd2, 32'h8, dummy);
      wr(2'd0, 32'd2, L);
      expq.push_back(L + 64);
      wait_to(L + 31); rd_chk("R3 div32 before", 2'd1, 32'd2);
      wait_to(L + 32); rd_chk("R3 div32 step", 2'd1, 32'd1);
      wait_to(L + 70);

      // R3 code 2 -> divide by 8
      wr(2'd2, 32'h2, dummy);
      wr(2'd0, 32'd1, L);
      expq.push_back(L + 8);
      wait_to(L + 7);  rd_chk("R3 div8 before", 2'd1, 32'd1);
      wait_to(L + 8);  rd_chk("R3 div8 end", 2'd1, 32'd0);
      wait_to(L + 12);

      // R6 periodic, start 3, divide by 1
      wr(2'd2, 32'hB, dummy);
      wr(2'd3, 32'h0002_0000, dummy);
      wr(2'd0, 32'd3, L);
      expq.push_back(L + 3); expq.push_back(L + 7); expq.push_back(L + 11);
      wait_to(L + 4);  rd_chk("R6 reload", 2'd1, 32'd3);
      wait_to(L + 12);
      // R9 stop with zero
      wr(2'd0, 32'd0, L2);
      wait_to(L2 + 20);
      rd_chk("R9 live stopped", 2'd1, 32'd0);
      rd_chk("R9 start zero", 2'd0, 32'd0);

      // R8 periodic start 1: pulses every other cycle
      wr(2'd0, 32'd1, L);
      expq.push_back(L + 1); expq.push_back(L + 3); expq.push_back(L + 5);
      wait_to(L + 5);
      wr(2'd0, 32'd0, L2);
      wait_to(L2 + 10);

      // R7 masked periodic keeps counting
      wr(2'd3, 32'h0003_0000, dummy);
      wr(2'd0, 32'd2, L);
      wait_to(L + 1);  rd_chk("R7 counts masked", 2'd1, 32'd1);
      wait_to(L + 20); rd_chk("R7 wraps masked", 2'd1, 32'd0);
      wr(2'd0, 32'd0, dummy);

      // R5 reload mid-count cancels old expiry
      wr(2'd3, 32'h0, dummy);
      wr(2'd0, 32'd10, L);
      wait_to(L + 4);  rd_chk("R5 before reload", 2'd1, 32'd6);
      wr(2'd0, 32'd3, L2);
      expq.push_back(L2 + 3);
      wait_to(L2 + 1); rd_chk("R5 after reload", 2'd1, 32'd2);
      wait_to(L + 20); rd_chk("R5 done", 2'd1, 32'd0);

      // R10 live count is read-only
      wr(2'd0, 32'd8, L);
      expq.push_back(L + 8);
      wait_to(L + 2);
      wr(2'd1, 32'h1234, L2);
      rd_chk("R10 live untouched", 2'd1, 32'(8 - (L2 - L)));
      rd_chk("R10 start untouched", 2'd0, 32'd8);
      wait_to(L + 12);

      chk("R4/R6 missing irq", 32'(expq.size()), 32'd0);
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule